// File: doc/BRIEF.md
# Up/Down Digital Potentiometer Wiper Controller

This block is the digital half of a 32-position digital potentiometer. It is controlled over three wires: an active-low select, a step strobe and a direction line. While the block is selected, each falling edge of the step strobe moves the wiper one tap up or down, as the direction line says. The wiper stops at either end of the range and never wraps. All three inputs are asynchronous to the system clock. They pass through two-flop synchronizers, and every decision is taken in the clock domain.

A shadow register models the nonvolatile store. When the select line goes high, the level of the step strobe at that moment decides what happens. If the strobe is high, the current tap is committed to the shadow register and a one-cycle store strobe is raised. If the strobe is low, the selection ends and nothing is saved. The main reset models a power cycle: after it, the wiper comes back at the saved tap. A separate reset input clears the shadow register to a parameterized mid-scale default, which models a part that has never been programmed.

Top module: `updown_wiper_ctrl`

## Requirements
- R1: While the main reset is held and after it is released, `tap` equals the saved value. With no save since the shadow reset, that value is DEFAULT_TAP (16).
- R2: While `sel_n` is high, changes on `step` and `dir_up` leave `tap` unchanged.
- R3: With `sel_n` low and `dir_up` = 1, each falling edge of `step` raises `tap` by one.
- R4: With `sel_n` low and `dir_up` = 0, each falling edge of `step` lowers `tap` by one.
- R5: `tap` holds at 31 when stepped up and at 0 when stepped down; it never wraps.
- R6: A rising edge of `sel_n` while `step` is high raises `store_stb` for exactly one clock cycle. The tap held at that time is what later power cycles restore.
- R7: A rising edge of `sel_n` while `step` is low raises no store strobe and leaves the saved value unchanged.
- R8: `dir_up` may change while `sel_n` stays low, and each step follows the direction in force at its own strobe edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset, released synchronously |
| nv_rst_n | input | 1 | Asynchronous active-low clear of the shadow register to DEFAULT_TAP |
| sel_n | input | 1 | Active-low select, asynchronous |
| step | input | 1 | Step strobe, active on its falling edge, asynchronous |
| dir_up | input | 1 | Step direction: 1 moves up, 0 moves down |
| tap | output | 5 | Current wiper tap index, 0 to 31 |
| store_stb | output | 1 | One-cycle pulse when a save is committed |

## Verification
The assertions rely on two properties of the inputs. First, the synchronized step strobe and select never change in the same clock cycle, so a step and a save decision are never seen together. Second, every input level is held for at least two clock cycles, so each edge passes through the synchronizer intact. The stimulus holds every level for five or more cycles. It never changes `step` and `sel_n` together, and the step edge that comes before a release without a save always lands well ahead of the select edge.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  // Bit positions inside the synchronized control vector
  localparam int unsigned CTL_SEL  = 0;
  localparam int unsigned CTL_STEP = 1;
  localparam int unsigned CTL_DIR  = 2;
  localparam int unsigned CTL_W    = 3;

  // Idle levels: deselected, strobe high, direction down
  localparam logic [CTL_W-1:0] CTL_IDLE = 3'b011;

endpackage

// File: rtl/wiper_rst_sync.sv
module wiper_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/wiper_in_sync.sv
module wiper_in_sync #(
  parameter int unsigned       WIDTH    = 3,
  parameter logic [WIDTH-1:0]  IDLE_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] prev
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] lvl_q;
  logic [WIDTH-1:0] prev_q;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q[g] <= IDLE_VAL[g];
          lvl_q[g]  <= IDLE_VAL[g];
          prev_q[g] <= IDLE_VAL[g];
        end else begin
          meta_q[g] <= async_in[g];
          lvl_q[g]  <= meta_q[g];
          prev_q[g] <= lvl_q[g];
        end
      end
    end
  endgenerate

  assign lvl  = lvl_q;
  assign prev = prev_q;

endmodule

// File: rtl/wiper_pos.sv
module wiper_pos
  import wiper_pkg::*;
#(
  parameter int unsigned TAP_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TAP_BITS-1:0] load_val,
  input  logic                step_en,
  input  dir_e                step_dir,
  output logic [TAP_BITS-1:0] tap,
  output logic                loaded
);

  localparam logic [TAP_BITS-1:0] TAP_MAX = {TAP_BITS{1'b1}};
  localparam logic [TAP_BITS-1:0] TAP_MIN = '0;

  logic [TAP_BITS-1:0] wiper_q, wiper_d;
  logic                loaded_q, loaded_d;
  logic                wiper_en;

  always_comb begin
    wiper_d  = wiper_q;
    loaded_d = loaded_q;
    wiper_en = 1'b0;
    if (!loaded_q) begin
      wiper_d  = load_val;
      loaded_d = 1'b1;
      wiper_en = 1'b1;
    end else if (step_en) begin
      if (step_dir == DIR_UP) begin
        if (wiper_q != TAP_MAX) begin
          wiper_d  = wiper_q + 1'b1;
          wiper_en = 1'b1;
        end
      end else begin
        if (wiper_q != TAP_MIN) begin
          wiper_d  = wiper_q - 1'b1;
          wiper_en = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
    end else begin
      loaded_q <= loaded_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q <= '0;
    end else if (wiper_en) begin
      wiper_q <= wiper_d;
    end
  end

  // Until the first clock after reset the saved value is shown directly
  assign tap    = loaded_q ? wiper_q : load_val;
  assign loaded = loaded_q;

endmodule

// File: rtl/wiper_store.sv
module wiper_store #(
  parameter int unsigned          TAP_BITS    = 5,
  parameter logic [TAP_BITS-1:0]  DEFAULT_TAP = 5'd16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                nv_rst_n,
  input  logic                save_req,
  input  logic [TAP_BITS-1:0] wiper,
  output logic                store_stb,
  output logic [TAP_BITS-1:0] saved
);

  logic                stb_q, stb_d;
  logic [TAP_BITS-1:0] shadow_q, shadow_d;
  logic                shadow_en;

  always_comb begin
    stb_d     = save_req;
    shadow_en = stb_q;
    shadow_d  = wiper;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
    end
  end

  // Shadow survives power-up reset; only the clear input returns it to default
  always_ff @(posedge clk or negedge nv_rst_n) begin
    if (!nv_rst_n) begin
      shadow_q <= DEFAULT_TAP;
    end else if (shadow_en) begin
      shadow_q <= shadow_d;
    end
  end

  assign store_stb = stb_q;
  assign saved     = shadow_q;

endmodule

// File: rtl/updown_wiper_ctrl.sv
module updown_wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int unsigned         TAP_BITS    = 5,
  parameter logic [TAP_BITS-1:0] DEFAULT_TAP = 5'd16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                nv_rst_n,
  input  logic                sel_n,
  input  logic                step,
  input  logic                dir_up,
  output logic [TAP_BITS-1:0] tap,
  output logic                store_stb
);

  logic                rst_sync_n;
  logic                nv_sync_n;
  logic [CTL_W-1:0]    ctl_raw;
  logic [CTL_W-1:0]    ctl_lvl;
  logic [CTL_W-1:0]    ctl_prev;
  logic                sel_hi;
  logic                step_fall;
  logic                sel_rise;
  logic                step_en;
  logic                save_req;
  dir_e                step_dir;
  logic                dir_lvl;
  logic                loaded;
  logic [TAP_BITS-1:0] saved;
  logic [TAP_BITS-1:0] tap_int;

  wiper_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  wiper_rst_sync #(.STAGES(2)) u_nv_rst_sync (
    .clk    (clk),
    .arst_n (nv_rst_n),
    .srst_n (nv_sync_n)
  );

  always_comb begin
    ctl_raw           = '0;
    ctl_raw[CTL_SEL]  = sel_n;
    ctl_raw[CTL_STEP] = step;
    ctl_raw[CTL_DIR]  = dir_up;
  end

  wiper_in_sync #(.WIDTH(CTL_W), .IDLE_VAL(CTL_IDLE)) u_in_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (ctl_raw),
    .lvl      (ctl_lvl),
    .prev     (ctl_prev)
  );

  always_comb begin
    sel_hi    = ctl_lvl[CTL_SEL];
    dir_lvl   = ctl_lvl[CTL_DIR];
    step_fall = ctl_prev[CTL_STEP] & ~ctl_lvl[CTL_STEP];
    sel_rise  = ctl_lvl[CTL_SEL] & ~ctl_prev[CTL_SEL];
    step_en   = step_fall & ~sel_hi;
    save_req  = sel_rise & ctl_lvl[CTL_STEP];
    step_dir  = dir_e'(dir_lvl);
  end

  wiper_pos #(.TAP_BITS(TAP_BITS)) u_pos (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_val (saved),
    .step_en  (step_en),
    .step_dir (step_dir),
    .tap      (tap_int),
    .loaded   (loaded)
  );

  wiper_store #(.TAP_BITS(TAP_BITS), .DEFAULT_TAP(DEFAULT_TAP)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .nv_rst_n  (nv_sync_n),
    .save_req  (save_req),
    .wiper     (tap_int),
    .store_stb (store_stb),
    .saved     (saved)
  );

  assign tap = tap_int;

endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int unsigned TAP_BITS = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [TAP_BITS-1:0] tap,
  input logic                store_stb,
  input logic                sel_hi,
  input logic                dir_lvl,
  input logic                loaded
);

  localparam logic [TAP_BITS-1:0] TAP_MAX = {TAP_BITS{1'b1}};

  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && sel_hi) |=> $stable(tap)); // R2

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && $past(loaded)) |->
      ((tap == $past(tap)) ||
       ({1'b0, tap} == {1'b0, $past(tap)} + 1'b1) ||
       ({1'b0, tap} + 1'b1 == {1'b0, $past(tap)}))); // R3 R4

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && tap == TAP_MAX && dir_lvl) |=> (tap != '0)); // R5

  AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && tap == '0 && !dir_lvl) |=> (tap != TAP_MAX)); // R5

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb |=> !store_stb); // R6

  AST_LOAD_SEAMLESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> (tap == $past(tap))); // R1

endmodule

bind updown_wiper_ctrl wiper_ctrl_chk #(.TAP_BITS(TAP_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tap       (tap),
  .store_stb (store_stb),
  .sel_hi    (sel_hi),
  .dir_lvl   (dir_lvl),
  .loaded    (loaded)
);

// File: tb/tb_updown_wiper_ctrl.sv
module tb_updown_wiper_ctrl;

  localparam int TAP_BITS = 5;
  localparam int TAP_MAX  = 31;
  localparam int DEF_TAP  = 16;

  logic                clk;
  logic                rst_n;
  logic                nv_rst_n;
  logic                sel_n;
  logic                step;
  logic                dir_up;
  logic [TAP_BITS-1:0] tap;
  logic                store_stb;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_tap;
  int exp_saved;
  bit done = 0;

  updown_wiper_ctrl #(.TAP_BITS(TAP_BITS), .DEFAULT_TAP(5'd16)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .nv_rst_n  (nv_rst_n),
    .sel_n     (sel_n),
    .step      (step),
    .dir_up    (dir_up),
    .tap       (tap),
    .store_stb (store_stb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One full strobe: falling edge (counts when selected), then back high
  task automatic pulse(input bit selected);
    step = 1'b0;
    idle(5);
    if (selected) begin
      if (dir_up) exp_tap = (exp_tap < TAP_MAX) ? exp_tap + 1 : TAP_MAX;
      else        exp_tap = (exp_tap > 0) ? exp_tap - 1 : 0;
    end
    step = 1'b1;
    idle(5);
  endtask

  task automatic power_cycle();
    rst_n = 1'b0;
    idle(3);
    exp_tap = exp_saved;
    check("R1 tap during reset", tap, exp_tap);
    rst_n = 1'b1;
    idle(6);
    check("R1 tap after reset", tap, exp_tap);
  endtask

  // Release select and count store strobes; returns the count
  task automatic release_sel(output int stb_cnt);
    stb_cnt = 0;
    sel_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (store_stb) stb_cnt++;
    end
  endtask

  initial begin
    int cnt;
    rst_n = 1'b0; nv_rst_n = 1'b0;
    sel_n = 1'b1; step = 1'b1; dir_up = 1'b0;
    exp_tap = DEF_TAP; exp_saved = DEF_TAP;
    idle(4);
    check("R1 unprogrammed tap in reset", tap, DEF_TAP);
    check("R6 no strobe in reset", store_stb, 0);
    rst_n = 1'b1; nv_rst_n = 1'b1;
    idle(6);
    check("R1 unprogrammed tap after reset", tap, DEF_TAP);

    // R2: standby ignores strobe and direction
    for (int d = 0; d < 2; d++) begin
      dir_up = d[0];
      for (int k = 0; k < 3; k++) begin
        pulse(1'b0);
        check("R2 standby tap", tap, exp_tap);
      end
    end

    // R3 / R5: sweep up past the top
    sel_n = 1'b0; idle(5);
    dir_up = 1'b1; idle(3);
    for (int k = 0; k < 20; k++) begin
      pulse(1'b1);
      check(exp_tap == TAP_MAX ? "R5 top hold" : "R3 step up", tap, exp_tap);
    end
    // R4 / R5: sweep down past the bottom
    dir_up = 1'b0; idle(3);
    for (int k = 0; k < 40; k++) begin
      pulse(1'b1);
      check(exp_tap == 0 ? "R5 bottom hold" : "R4 step down", tap, exp_tap);
    end

    // R8: reverse direction within the same selection
    dir_up = 1'b1; idle(3);
    for (int k = 0; k < 5; k++) pulse(1'b1);
    dir_up = 1'b0; idle(3);
    for (int k = 0; k < 2; k++) pulse(1'b1);
    dir_up = 1'b1; idle(3);
    for (int k = 0; k < 3; k++) pulse(1'b1);
    check("R8 mixed direction", tap, 6);

    // R6: release with strobe high saves
    release_sel(cnt);
    exp_saved = exp_tap;
    check("R6 one store strobe", cnt, 1);
    check("R6 tap kept", tap, 6);

    // R7: move, end on a falling edge, release with strobe low
    sel_n = 1'b0; idle(5);
    dir_up = 1'b0; idle(3);
    pulse(1'b1);
    pulse(1'b1);
    step = 1'b0; idle(6);
    exp_tap = exp_tap - 1;
    check("R7 tap before release", tap, 3);
    release_sel(cnt);
    check("R7 no store strobe", cnt, 0);
    step = 1'b1; idle(5);
    check("R7 tap unchanged", tap, 3);
    power_cycle();
    check("R7 saved value kept", tap, 6);

    // R6 / R1: save and restore every tap
    sel_n = 1'b0; idle(5);
    dir_up = 1'b0; idle(3);
    for (int k = 0; k < 8; k++) pulse(1'b1);
    dir_up = 1'b1; idle(3);
    for (int v = 0; v <= TAP_MAX; v++) begin
      release_sel(cnt);
      check("R6 strobe per save", cnt, 1);
      exp_saved = v;
      power_cycle();
      check("R6 restored tap", tap, v);
      sel_n = 1'b0; idle(5);
      if (v < TAP_MAX) pulse(1'b1);
    end
    sel_n = 1'b1; idle(6);

    // R1: shadow clear returns to default
    nv_rst_n = 1'b0; idle(3);
    nv_rst_n = 1'b1; idle(3);
    exp_saved = DEF_TAP;
    power_cycle();
    check("R1 default after clear", tap, DEF_TAP);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule